// File: doc/BRIEF.md
# Flash Operation Status Generator

This block sits on the device side of a NOR-style flash and produces what the host sees when it reads the part while an internal operation is running. The operations are a program, an erase, an erase or program suspend, a program issued during an erase suspend, and a buffered write. The block forms an 8-bit status word and an active-low ready/busy flag. It also forms a selector that tells the surrounding read path to return array data instead of status. The memory array, the command decoder and the algorithm timers sit outside the block. They supply the operation mode, a flag saying whether the addressed sector is the one being worked on, bit 7 of the data being programmed, a time-limit flag and a buffered-write abort flag.

Two status bits change on every host read while their condition holds: bit 6 and bit 2. Each one comes from its own flip-flop, which inverts once per read strobe. A host can poll either bit and tell "still running" from "done" without any timing of its own. The operation mode is captured on each clock edge. Ready/busy and status therefore follow the command decoder's mode one clock after it changes, which is one clock after the final write strobe of a command sequence.

Top module: `flash_status_gen`

## Requirements
- R1: Mode codes are: 0 array read, 1 program, 2 erase, 3 erase-suspend, 4 program-suspend, 5 program within erase-suspend, 6 buffered write. Code 7 behaves like 0. In array read, selArray=1, rdyBusyN=1 and statusWord=0.
- R2: In program mode, bit 7 is the inverse of dataBit7 and bit 6 is the bit-6 toggle flop. Bit 2 shows the bit-2 toggle flop but does not change. Bits 5 (without timeout) and 1 are 0, and rdyBusyN=0.
- R3: In erase mode, bit 7=0, bit 3=1, and bits 6 and 2 show their toggle flops, both toggling. rdyBusyN=0.
- R4: In erase-suspend with inTargetSector=1, bit 7=1, bit 6 shows its flop without toggling, bit 2 toggles, and rdyBusyN=1. With inTargetSector=0, selArray=1 and rdyBusyN=1.
- R5: In program-suspend with inTargetSector=1, the access is invalid: statusWord=0, selArray=0, rdyBusyN=1. With inTargetSector=0, selArray=1 and rdyBusyN=1.
- R6: In program within erase-suspend, bit 7 is the inverse of dataBit7, bit 6 toggles, bit 2 is 0 and rdyBusyN=0.
- R7: In buffered write, bit 7 is the inverse of dataBit7, bit 6 toggles, bit 1 equals abortFlag, and rdyBusyN=0.
- R8: Bit 5 equals timeoutFlag in modes 1, 2, 5 and 6, and is 0 in every other mode.
- R9: The bit-6 flop inverts on a clock edge with readStrobe=1 while the registered mode is 1, 2, 5 or 6. The bit-2 flop inverts on such an edge while the mode is 2, or 3 with inTargetSector=1. Otherwise both flops hold.
- R10: Outputs follow a change of opMode on the first clock edge after it. The data, sector, timeout and abort inputs act combinationally.
- R11: While rstN=0, the mode returns to array read at once, both toggle flops clear to 0, and the strobe and mode inputs have no effect.
- R12: Bits 4 and 0 are always 0. Any bit that a mode does not define is 0. statusWord is 0 whenever selArray=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 3 | Operation mode from the command decoder (codes in R1) |
| inTargetSector | input | 1 | The read address lies in the sector under operation |
| dataBit7 | input | 1 | Bit 7 of the word being programmed |
| timeoutFlag | input | 1 | The operation exceeded its time limit |
| abortFlag | input | 1 | The buffered write was aborted |
| readStrobe | input | 1 | One host status read per cycle high |
| statusWord | output | 8 | Status byte |
| selArray | output | 1 | Return array data instead of status |
| rdyBusyN | output | 1 | Low while an internal operation is running |

## Verification
The bench mixes read strobes with sector changes across every mode boundary, so both toggle flops reach each mode in both phases. A design that toggled bit 6 on the suspended sector, or bit 2 during a plain program, would drift out of phase and be reported. Mode changes are applied one cycle at a time. A design that decoded opMode directly would show the new mode one cycle early. A design that kept toggle state across a mid-operation reset would show a stale bit 6 after release. Timeout and abort are also raised in modes that ignore them, which catches a bit 5 or bit 1 that leaks outside the busy modes.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int MODE_W   = 3;
  localparam int STATUS_W = 8;

  // bit positions of the status byte, decoded by the host
  localparam int POS_POLL   = 7;
  localparam int POS_TOGA   = 6;
  localparam int POS_LIMIT  = 5;
  localparam int POS_ERASE  = 3;
  localparam int POS_TOGB   = 2;
  localparam int POS_ABORT  = 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_ARRAY      = 3'd0,
    MODE_PROG       = 3'd1,
    MODE_ERASE      = 3'd2,
    MODE_ESUSP      = 3'd3,
    MODE_PSUSP      = 3'd4,
    MODE_ESUSP_PROG = 3'd5,
    MODE_BUFWR      = 3'd6,
    MODE_SPARE      = 3'd7
  } opMode_e;

  typedef enum logic [1:0] {
    POLL_ZERO = 2'd0,
    POLL_ONE  = 2'd1,
    POLL_INV  = 2'd2
  } pollSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     flipA;
    logic     flipB;
    logic     showA;
    logic     showB;
    pollSel_e pollSel;
    logic     limitEn;
    logic     eraseMark;
    logic     abortEn;
    logic     pickArray;
    logic     busy;
  } statusCtrl_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] opMode,
  input  logic              inTargetSector,
  input  logic              readStrobe,
  output statusCtrl_t       ctrl
);

  opMode_e modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_ARRAY;
    else       modeQ <= opMode_e'(opMode);
  end

  logic toggleA;
  logic toggleB;

  always_comb begin
    ctrl    = '0;
    toggleA = 1'b0;
    toggleB = 1'b0;
    unique case (modeQ)
      MODE_PROG: begin
        ctrl.showA   = 1'b1;
        ctrl.showB   = 1'b1;
        ctrl.pollSel = POLL_INV;
        ctrl.limitEn = 1'b1;
        ctrl.busy    = 1'b1;
        toggleA      = 1'b1;
      end
      MODE_ERASE: begin
        ctrl.showA     = 1'b1;
        ctrl.showB     = 1'b1;
        ctrl.pollSel   = POLL_ZERO;
        ctrl.limitEn   = 1'b1;
        ctrl.eraseMark = 1'b1;
        ctrl.busy      = 1'b1;
        toggleA        = 1'b1;
        toggleB        = 1'b1;
      end
      MODE_ESUSP: begin
        if (inTargetSector) begin
          ctrl.showA   = 1'b1;
          ctrl.showB   = 1'b1;
          ctrl.pollSel = POLL_ONE;
          toggleB      = 1'b1;
        end else begin
          ctrl.pickArray = 1'b1;
        end
      end
      MODE_PSUSP: begin
        ctrl.pickArray = !inTargetSector;
      end
      MODE_ESUSP_PROG, MODE_BUFWR: begin
        ctrl.showA   = 1'b1;
        ctrl.pollSel = POLL_INV;
        ctrl.limitEn = 1'b1;
        ctrl.abortEn = (modeQ == MODE_BUFWR);
        ctrl.busy    = 1'b1;
        toggleA      = 1'b1;
      end
      default: begin
        ctrl.pickArray = 1'b1;
      end
    endcase
    ctrl.flipA = toggleA && readStrobe;
    ctrl.flipB = toggleB && readStrobe;
  end

  AST_ARRAY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pickArray |-> !ctrl.busy); // R1

  AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ESUSP || modeQ == MODE_PSUSP) |-> !ctrl.busy && !ctrl.flipA); // R4

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  statusCtrl_t         ctrl,
  input  logic                dataBit7,
  input  logic                timeoutFlag,
  input  logic                abortFlag,
  output logic [STATUS_W-1:0] statusWord,
  output logic                selArray,
  output logic                rdyBusyN
);

  logic togAQ;
  logic togBQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togAQ <= 1'b0;
      togBQ <= 1'b0;
    end else begin
      if (ctrl.flipA) togAQ <= !togAQ;
      if (ctrl.flipB) togBQ <= !togBQ;
    end
  end

  logic pollBit;

  always_comb begin
    unique case (ctrl.pollSel)
      POLL_ONE: pollBit = 1'b1;
      POLL_INV: pollBit = !dataBit7;
      default:  pollBit = 1'b0;
    endcase
  end

  always_comb begin
    statusWord            = '0;
    statusWord[POS_POLL]  = pollBit;
    statusWord[POS_TOGA]  = ctrl.showA && togAQ;
    statusWord[POS_LIMIT] = ctrl.limitEn && timeoutFlag;
    statusWord[POS_ERASE] = ctrl.eraseMark;
    statusWord[POS_TOGB]  = ctrl.showB && togBQ;
    statusWord[POS_ABORT] = ctrl.abortEn && abortFlag;
  end

  assign selArray = ctrl.pickArray;
  assign rdyBusyN = !ctrl.busy;

  AST_TOGA_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flipA |=> togAQ != $past(togAQ)); // R9

  AST_TOGB_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.flipB |=> $stable(togBQ)); // R9

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   opMode,
  input  logic                inTargetSector,
  input  logic                dataBit7,
  input  logic                timeoutFlag,
  input  logic                abortFlag,
  input  logic                readStrobe,
  output logic [STATUS_W-1:0] statusWord,
  output logic                selArray,
  output logic                rdyBusyN
);

  statusCtrl_t ctrl;

  flash_status_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .opMode         (opMode),
    .inTargetSector (inTargetSector),
    .readStrobe     (readStrobe),
    .ctrl           (ctrl)
  );

  flash_status_dp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .dataBit7    (dataBit7),
    .timeoutFlag (timeoutFlag),
    .abortFlag   (abortFlag),
    .statusWord  (statusWord),
    .selArray    (selArray),
    .rdyBusyN    (rdyBusyN)
  );

  AST_LIMIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[POS_LIMIT] |-> !rdyBusyN); // R8

  AST_ABORT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[POS_ABORT] |-> !rdyBusyN); // R7

  AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    selArray |-> statusWord == '0); // R12

endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opMode = 3'd0;
  logic       inTargetSector = 1'b0;
  logic       dataBit7 = 1'b0;
  logic       timeoutFlag = 1'b0;
  logic       abortFlag = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] statusWord;
  logic       selArray;
  logic       rdyBusyN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int refMode = 0;
  bit refTogA = 0;
  bit refTogB = 0;

  always #5 clk = !clk;

  flash_status_gen i_flash_status_gen (
    .clk(clk), .rstN(rstN), .opMode(opMode), .inTargetSector(inTargetSector),
    .dataBit7(dataBit7), .timeoutFlag(timeoutFlag), .abortFlag(abortFlag),
    .readStrobe(readStrobe), .statusWord(statusWord), .selArray(selArray),
    .rdyBusyN(rdyBusyN)
  );

  function automatic string tagOf(int m);
    case (m)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R1";
    endcase
  endfunction

  // expected outputs from the requirement tables
  task automatic expect_now(output logic [7:0] w, output bit sa, output bit rb);
    w = 8'h00; sa = 0; rb = 1;
    case (refMode)
      1: begin w[7] = !dataBit7; w[6] = refTogA; w[2] = refTogB; w[5] = timeoutFlag; rb = 0; end
      2: begin w[6] = refTogA; w[3] = 1; w[2] = refTogB; w[5] = timeoutFlag; rb = 0; end
      3: if (inTargetSector) begin w[7] = 1; w[6] = refTogA; w[2] = refTogB; end else sa = 1;
      4: sa = !inTargetSector;
      5: begin w[7] = !dataBit7; w[6] = refTogA; w[5] = timeoutFlag; rb = 0; end
      6: begin w[7] = !dataBit7; w[6] = refTogA; w[5] = timeoutFlag; w[1] = abortFlag; rb = 0; end
      default: sa = 1;
    endcase
  endtask

  task automatic compare(input string tag);
    logic [7:0] w; bit sa; bit rb;
    expect_now(w, sa, rb);
    checks++;
    if (statusWord !== w || selArray !== sa || rdyBusyN !== rb) begin
      errors++;
      $display("FAIL %s mode=%0d: actual word=%h sel=%b rdy=%b expected word=%h sel=%b rdy=%b",
               tag, refMode, statusWord, selArray, rdyBusyN, w, sa, rb);
    end
  endtask

  // R9 toggle conditions, R10 one-edge mode capture, R11 reset
  task automatic step(input int m, input bit t, input bit d, input bit to,
                      input bit ab, input bit rd, input bit rs, input string tag);
    opMode = m[2:0]; inTargetSector = t; dataBit7 = d;
    timeoutFlag = to; abortFlag = ab; readStrobe = rd; rstN = rs;
    if (!rs) begin refMode = 0; refTogA = 0; refTogB = 0; end
    @(posedge clk);
    if (rs) begin
      if (rd && (refMode == 1 || refMode == 2 || refMode == 5 || refMode == 6)) refTogA = !refTogA;
      if (rd && (refMode == 2 || (refMode == 3 && t))) refTogB = !refTogB;
      refMode = m;
    end
    @(negedge clk);
    compare(tag.len() > 0 ? tag : tagOf(refMode));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare("R11 reset state");
    // R1 array read, spare code
    step(0, 0, 1, 1, 1, 1, 1, "R1");
    step(7, 1, 1, 1, 1, 1, 1, "R1");
    // R2 program, reads toggle bit 6, bit 2 frozen
    for (int i = 0; i < 4; i++) step(1, i[0], i[1], 0, 0, 1, 1, "R2");
    step(1, 0, 0, 1, 0, 0, 1, "R8");
    // R3 erase, both toggle
    for (int i = 0; i < 5; i++) step(2, 1, 0, 0, 0, i != 2, 1, "R3");
    // R4 erase-suspend target and other sector
    for (int i = 0; i < 4; i++) step(3, 1, 0, 1, 1, 1, 1, "R4");
    step(3, 0, 0, 0, 0, 1, 1, "R4");
    step(3, 0, 0, 0, 0, 1, 1, "R4 other sector");
    // R5 program-suspend
    step(4, 1, 1, 1, 1, 1, 1, "R5");
    step(4, 1, 1, 1, 1, 1, 1, "R5 invalid");
    step(4, 0, 1, 1, 1, 1, 1, "R5 other sector");
    // R6 program in erase-suspend
    for (int i = 0; i < 3; i++) step(5, 1, i[0], 0, 0, 1, 1, "R6");
    // R7 buffered write and abort
    step(6, 0, 1, 0, 0, 1, 1, "R7");
    step(6, 0, 1, 0, 1, 1, 1, "R7 abort");
    step(6, 0, 0, 1, 0, 0, 1, "R8 timeout");
    // R10 mode change takes one edge
    opMode = 3'd2; #1; compare("R10 before edge");
    step(2, 0, 0, 0, 0, 0, 1, "R10");
    // R11 reset mid-operation ignores strobes
    step(1, 0, 0, 0, 0, 1, 0, "R11");
    step(1, 0, 0, 0, 0, 1, 0, "R11");
    step(1, 0, 0, 0, 0, 1, 1, "R11 release");
    // R12 random mix over all modes
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom);
      step(r & 7, r[3], r[4], r[5], r[6], r[7], (r % 97) != 0, "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule